// File: doc/BRIEF.md
# Quadrature Pulse Train Generator

This block emits a finite burst of quadrature encoder signals, channels A and B plus an index line, so that a receiver sees a rotary encoder move by an exact number of edges. The host writes burst parameter sets ahead of time into a small queue. Each set holds four values: the spacing between edges in system clocks, the total number of A+B edges, and the edge numbers at which the index line rises and falls.

A rising edge on the load input takes the oldest set from the queue and starts the burst. After that the block runs with no further host action. A divider makes one edge tick every programmed period. On each tick exactly one of A or B toggles, and the direction input sets which channel leads. When the programmed edge total is reached, the outputs freeze and a done flag rises. The host waits for done before it loads the next set or changes direction.

Top module: `qpt_gen`

## Requirements
- R1: A rising edge on `load`, accepted while the queue is not empty and no burst is running, pops the oldest parameter set and starts a burst. The clock edge that accepts the load also clears `done`, unless the edge total is 0.
- R2: Edge k of a burst (k = 1, 2, ...) appears on A or B exactly k×P clocks after the clock edge that accepted the load. P is the programmed period, and a period of 0 is treated as 1.
- R3: Each edge tick toggles exactly one of `qa` and `qb`, never both. With `dir` = 1 the state {qa,qb} steps forward 00 → 10 → 11 → 01 → 00, so A leads B. Without a tick, A and B do not move. After reset A and B are both 0.
- R4: With `dir` = 0 the same sequence is walked in reverse (00 → 01 → 11 → 10 → 00), so B leads A.
- R5: A burst stops after exactly the programmed number of edges. `done` rises on the clock edge that produces the last edge. After that `qa`, `qb` and `qi` hold their levels until the next burst.
- R6: The index `qi` goes to 1 on the edge whose running edge number equals the rise value, and to 0 on the edge whose number equals the fall value. If both values are equal, the fall value wins. Between those edges and between bursts `qi` holds its level. Values of 0xFFFFFFFF are never reached, so the index does not change.
- R7: A set with an edge total of 0 sets `done` on the accepting clock edge and toggles no output.
- R8: A rising edge on `load` is ignored if the queue is empty or a burst is running. Such an edge leaves the running burst and the outputs untouched and sets `load_err`, which stays 1 until reset.
- R9: The queue holds 4 sets. `fifo_full` is 1 while 4 sets are stored, and a write while full is dropped.
- R10: After reset `qa`, `qb`, `qi`, `done`, `load_err` and `fifo_full` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one parameter set into the queue |
| wr_period | input | 32 | Clocks between edges (0 behaves as 1) |
| wr_edges | input | 32 | Total A+B edges of the burst |
| wr_idx_rise | input | 32 | Edge number at which the index rises |
| wr_idx_fall | input | 32 | Edge number at which the index falls |
| fifo_full | output | 1 | Queue holds its maximum number of sets |
| load | input | 1 | Rising edge starts the next burst |
| dir | input | 1 | 1: A leads B, 0: B leads A |
| qa | output | 1 | Quadrature channel A |
| qb | output | 1 | Quadrature channel B |
| qi | output | 1 | Index output |
| done | output | 1 | Burst complete |
| load_err | output | 1 | Sticky flag for a rejected load edge |

## Verification
A corrupted divider count shows up as an edge one or more clocks away from its k×P slot, so the bench compares A, B and the index every clock rather than only at the end of a burst. A wrong edge counter or halt state shows at the last edge: either an extra toggle appears after `done`, or `done` rises one tick early or late. A wrong quadrature state appears at the very next tick, either as a double toggle or as a step in the wrong direction. A wrong accept decision shows up as a `load_err` that is set or missing, or as a burst that restarts.

// File: rtl/qpt_pkg.sv
package qpt_pkg;
  localparam int QPT_W = 32;

  typedef struct packed {
    logic [QPT_W-1:0] period;
    logic [QPT_W-1:0] total;
    logic [QPT_W-1:0] rise;
    logic [QPT_W-1:0] fall;
  } qpt_cfg_t;

  // Period used by the divider: zero behaves as one.
  function automatic logic [QPT_W-1:0] eff_period(input logic [QPT_W-1:0] p);
    return (p == '0) ? QPT_W'(1) : p;
  endfunction

  // One Gray step of {A,B}; fwd=1 walks 00,10,11,01.
  function automatic logic [1:0] next_ab(input logic [1:0] ab, input logic fwd);
    logic [1:0] n;
    case (ab)
      2'b00:   n = fwd ? 2'b10 : 2'b01;
      2'b10:   n = fwd ? 2'b11 : 2'b00;
      2'b11:   n = fwd ? 2'b01 : 2'b10;
      default: n = fwd ? 2'b00 : 2'b11;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/qpt_fifo.sv
module qpt_fifo
  import qpt_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  qpt_cfg_t din,
  input  logic     pop,
  output qpt_cfg_t dout,
  output logic     empty,
  output logic     full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  qpt_cfg_t        mem [DEPTH];
  logic [AW-1:0]   wptr, rptr;
  logic [CW-1:0]   fill;
  logic            do_push, do_pop;

  assign empty   = (fill == '0);
  assign full    = (fill == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (do_push) begin
        mem[wptr] <= din;
        wptr      <= bump(wptr);
      end
      if (do_pop) rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/qpt_tick.sv
module qpt_tick
  import qpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [QPT_W-1:0] period,
  output logic             tick
);
  logic [QPT_W-1:0] cnt;
  logic [QPT_W-1:0] last;

  assign last = eff_period(period) - QPT_W'(1);
  assign tick = run && (cnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= '0;
    else if (run)     cnt <= cnt + QPT_W'(1);
  end
endmodule

// File: rtl/qpt_quad.sv
module qpt_quad
  import qpt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fwd,
  output logic qa,
  output logic qb
);
  logic [1:0] ab;

  assign qa = ab[1];
  assign qb = ab[0];

  always_ff @(posedge clk) begin
    if (!rst_n)    ab <= 2'b00;
    else if (tick) ab <= next_ab(ab, fwd);
  end
endmodule

// File: rtl/qpt_gen.sv
module qpt_gen
  import qpt_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [QPT_W-1:0] wr_period,
  input  logic [QPT_W-1:0] wr_edges,
  input  logic [QPT_W-1:0] wr_idx_rise,
  input  logic [QPT_W-1:0] wr_idx_fall,
  output logic             fifo_full,
  input  logic             load,
  input  logic             dir,
  output logic             qa,
  output logic             qb,
  output logic             qi,
  output logic             done,
  output logic             load_err
);
  qpt_cfg_t         wr_cfg, head, cur;
  logic             fifo_empty;
  logic             load_q, load_rise, accept, bad_load;
  logic             running, tick;
  logic [QPT_W-1:0] edge_cnt, edge_nxt;

  assign wr_cfg    = '{period: wr_period, total: wr_edges, rise: wr_idx_rise, fall: wr_idx_fall};
  assign load_rise = load && !load_q;
  assign accept    = load_rise && !fifo_empty && !running;
  assign bad_load  = load_rise && (fifo_empty || running);
  assign edge_nxt  = edge_cnt + QPT_W'(1);

  qpt_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .din(wr_cfg),
    .pop(accept), .dout(head), .empty(fifo_empty), .full(fifo_full)
  );

  qpt_tick u_tick (
    .clk(clk), .rst_n(rst_n), .restart(accept), .run(running),
    .period(cur.period), .tick(tick)
  );

  qpt_quad u_quad (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fwd(dir), .qa(qa), .qb(qb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q   <= 1'b0;
      load_err <= 1'b0;
      cur      <= '0;
      edge_cnt <= '0;
      running  <= 1'b0;
      done     <= 1'b0;
      qi       <= 1'b0;
    end else begin
      load_q <= load;
      if (bad_load) load_err <= 1'b1;
      if (accept) begin
        cur      <= head;
        edge_cnt <= '0;
        running  <= (head.total != '0);
        done     <= (head.total == '0);
      end else if (tick) begin
        edge_cnt <= edge_nxt;
        if (edge_nxt == cur.total) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
        if (edge_nxt == cur.fall)      qi <= 1'b0;
        else if (edge_nxt == cur.rise) qi <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/qpt_gen_chk.sv
module qpt_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic qa,
  input logic qb,
  input logic done,
  input logic load_err,
  input logic running,
  input logic tick,
  input logic accept,
  input logic bad_load
);
  // R3: never both channels in one clock
  a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    !((qa != $past(qa)) && (qb != $past(qb))));

  // R3: A or B moves only after an edge tick
  a_r3_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ((qa != $past(qa)) || (qb != $past(qb))) |-> $past(tick));

  // R5: outputs frozen while halted
  a_r5_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !accept) |=> ($stable(qa) && $stable(qb)));

  // R5: halting always reports completion
  a_r5_done_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> done);

  // R8: error flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |=> load_err);

  // R8: error only from a rejected load edge
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_err) |-> $past(bad_load));

  // R8: a rejected edge never restarts the burst
  a_r8_no_accept_running: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !accept);
endmodule

bind qpt_gen qpt_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .qa(qa), .qb(qb), .done(done),
  .load_err(load_err), .running(running), .tick(tick),
  .accept(accept), .bad_load(bad_load)
);

// File: tb/qpt_gen_test.sv
module qpt_gen_test;
  localparam int  W  = 32;
  localparam logic [W-1:0] NEVER = 32'hFFFF_FFFF;

  typedef struct packed {
    logic         dir;
    logic [W-1:0] per;
    logic [W-1:0] cnt;
    logic [W-1:0] rise;
    logic [W-1:0] fall;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'd3, 32'd8, 32'd2, 32'd5},
    '{1'b0, 32'd1, 32'd6, 32'd1, 32'd4},
    '{1'b1, 32'd0, 32'd5, NEVER, NEVER},
    '{1'b0, 32'd2, 32'd3, 32'd3, NEVER},
    '{1'b1, 32'd4, 32'd4, NEVER, 32'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, load = 1'b0, dir = 1'b1;
  logic [W-1:0] wr_period = '0, wr_edges = '0, wr_idx_rise = '0, wr_idx_fall = '0;
  logic fifo_full, qa, qb, qi, done, load_err;

  int checks = 0, fails = 0;
  int pos = 0;
  logic qi_m = 1'b0;

  always #5 clk = ~clk;

  qpt_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_period(wr_period),
    .wr_edges(wr_edges), .wr_idx_rise(wr_idx_rise), .wr_idx_fall(wr_idx_fall),
    .fifo_full(fifo_full), .load(load), .dir(dir), .qa(qa), .qb(qb),
    .qi(qi), .done(done), .load_err(load_err)
  );

  function automatic logic [1:0] gray(input int p);
    int m;
    m = ((p % 4) + 4) % 4;
    case (m)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    pos = 0;
    qi_m = 1'b0;
  endtask

  task automatic push(input logic [W-1:0] p, input logic [W-1:0] c,
                      input logic [W-1:0] r, input logic [W-1:0] f);
    @(posedge clk);
    #1;
    wr_period = p; wr_edges = c; wr_idx_rise = r; wr_idx_fall = f; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  // Returns 1 ns after the accepting edge.
  task automatic pulse_load();
    @(posedge clk);
    #1 load = 1'b1;
    @(posedge clk);
    #1 load = 0;
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R10 reset state
    chk({qa, qb, qi, done, load_err, fifo_full} == 6'b0, "R10", {qa, qb, qi, done, load_err, fifo_full}, 0);

    // R8: load with empty queue
    pulse_load();
    @(posedge clk); #1;
    chk(load_err == 1'b1, "R8 empty", load_err, 1);
    chk({qa, qb, done} == 3'b000, "R8 empty no start", {qa, qb, done}, 0);

    // R9: queue depth and dropped write
    do_reset();
    for (int i = 0; i < 5; i++) begin
      push(32'd1, 32'd1, NEVER, NEVER);
      if (i == 2) chk(fifo_full == 1'b0, "R9 not full at 3", fifo_full, 0);
      if (i == 3) chk(fifo_full == 1'b1, "R9 full at 4", fifo_full, 1);
    end
    for (int i = 0; i < 4; i++) begin
      pulse_load();
      repeat (2) @(posedge clk);
      #1;
    end
    chk(fifo_full == 1'b0, "R9 drained", fifo_full, 0);
    chk(load_err == 1'b0, "R9 four accepted", load_err, 0);
    chk({qa, qb} == gray(4), "R9 four edges", {qa, qb}, gray(4));
    pulse_load();
    @(posedge clk); #1;
    chk(load_err == 1'b1, "R9 fifth write dropped", load_err, 1);

    // Table of bursts: R1 R2 R3 R4 R5 R6
    do_reset();
    for (int v = 0; v < NV; v++) begin
      int pe, tot, e, prev_e;
      vec_t t;
      t = VEC[v];
      pe = (t.per == 0) ? 1 : int'(t.per);
      tot = int'(t.cnt);
      dir = t.dir;
      push(t.per, t.cnt, t.rise, t.fall);
      pulse_load();
      chk(done == 1'b0, "R1 done cleared", done, 0);
      prev_e = 0;
      for (int c = 1; c <= tot * pe + 3; c++) begin
        logic [1:0] exp_ab;
        @(posedge clk); #1;
        e = c / pe;
        if (e > tot) e = tot;
        for (int k = prev_e + 1; k <= e; k++) begin
          if (k == int'(t.fall) && t.fall != NEVER) qi_m = 1'b0;
          else if (k == int'(t.rise) && t.rise != NEVER) qi_m = 1'b1;
        end
        prev_e = e;
        exp_ab = gray(pos + (t.dir ? e : -e));
        chk({qa, qb} == exp_ab, t.dir ? "R2 R3 fwd" : "R2 R4 rev", {qa, qb}, exp_ab);
        chk(qi == qi_m, "R6 index", qi, qi_m);
        chk(done == (e == tot), "R5 done", done, (e == tot));
      end
      pos = pos + (t.dir ? tot : -tot);
    end

    // R7: zero edges
    push(32'd2, 32'd0, 32'd0, 32'd0);
    pulse_load();
    chk(done == 1'b1, "R7 done at once", done, 1);
    repeat (4) @(posedge clk);
    #1;
    chk({qa, qb} == gray(pos), "R7 no toggle", {qa, qb}, gray(pos));
    chk(qi == qi_m, "R7 index held", qi, qi_m);

    // R8: load while running
    do_reset();
    dir = 1'b1;
    push(32'd5, 32'd4, NEVER, NEVER);
    push(32'd1, 32'd9, NEVER, NEVER);
    pulse_load();
    repeat (3) @(posedge clk);
    pulse_load();
    @(posedge clk); #1;
    chk(load_err == 1'b1, "R8 busy", load_err, 1);
    repeat (20) @(posedge clk);
    #1;
    chk({qa, qb} == gray(4), "R8 burst untouched", {qa, qb}, gray(4));
    chk(done == 1'b1, "R8 burst finished", done, 1);
    chk(load_err == 1'b1, "R8 sticky", load_err, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule